// File: doc/BRIEF.md
# Register-Bank I2C Target with Auto-Advancing Pointer

This block is an I2C-bus target that gives a host access to a bank of 8-bit control registers. The register file itself lives outside the block. The block brings out a one-cycle write strobe with address and data. It also presents a read address and takes the addressed byte back on a combinational read-data input. SCL and SDA are open-drain lines. Each line is modelled as a plain input. SDA also has an output enable, and while that enable is high the line is pulled low.

The target answers one of two fixed 7-bit device addresses. A strap input picks which one. A write transfer carries a subaddress byte that loads an internal 8-bit pointer, followed by any number of data bytes. Each data byte is written at the pointer, and the pointer then advances. A read transfer has no subaddress phase. It sends bytes starting at whatever the pointer holds and advances after each byte. A read therefore normally follows a short write that only sets the pointer, or a repeated START after such a write.

Both lines are resynchronised to the system clock, so the system clock must run well above the SCL rate. The register ports have no back-pressure: a write strobe must be accepted in the cycle it appears, and read data must be valid in the same cycle as its address.

Top module: `regbus_i2c_slave`

## Requirements
- R1: While reset is asserted and right after it, `sda_oe` is 0, `wr_en` is 0 and `rd_addr` is 0x00.
- R2: A byte after START whose upper seven bits equal 7'b1000100 (with `addr_sel`=0) or 7'b1000110 (with `addr_sel`=1) is acknowledged. Bit 0 of that byte is the direction: 0 means write, 1 means read.
- R3: On an address mismatch the target never drives SDA, acknowledges nothing and writes nothing until the next START.
- R4: In a write transfer the target drives ACK (SDA low) in the ninth clock after the subaddress byte and after every data byte.
- R5: In a write, the first byte after the address loads the pointer. Each later byte produces one single-cycle `wr_en` with `wr_addr` set to the pointer and `wr_data` set to the byte. The pointer then increments.
- R6: A read transfer takes no subaddress. It returns `rd_data` for the current pointer, MSB first. The pointer increments after each byte sent.
- R7: When the host answers a read byte with NACK, the target releases SDA and drives nothing more until the next START.
- R8: The pointer is 8 bits wide and wraps from 0xFF to 0x00.
- R9: A repeated START without an intervening STOP restarts address reception. The pointer is kept.
- R10: After a STOP the target ignores clocked bytes until a START. The target changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Strap: 0 selects address 1000100, 1 selects 1000110 |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, the target pulls SDA low |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register address for the write |
| wr_data | output | 8 | Register data for the write |
| rd_addr | output | 8 | Current pointer, used as the register read address |
| rd_data | input | 8 | Register contents at `rd_addr`, combinational |

## Verification
The hardest case to reach is the pointer wrap inside one burst, where a write crosses from 0xFF to 0x00 and a read then resumes from the wrapped value with no subaddress. The stimulus loads subaddress 0xFE, writes three bytes, and then opens a read that must start at 0x01.

The NACK release is also hard to see from the ports. To expose it, the bench clocks one more SCL pulse after the NACK and checks that the wired-AND line stays high. A repeated START that follows a one-byte write confirms that the pointer carries across the restart.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_SUB, S_WDAT, S_ACKW, S_ACKD,
    S_RD, S_RGAP, S_RACK, S_RNXT, S_IGN
  } i2cs_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_s, sda_s;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[STAGES-2:0], scl_i};
      sda_s <= {sda_s[STAGES-2:0], sda_i};
      scl_p <= scl_s[STAGES-1];
      sda_p <= sda_s[STAGES-1];
    end
  end

  assign scl_q     = scl_s[STAGES-1];
  assign sda_q     = sda_s[STAGES-1];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int         DW     = 8,
  parameter int         AW     = 8,
  parameter logic [6:0] ADDR_A = 7'b1000100,
  parameter logic [6:0] ADDR_B = 7'b1000110
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_sel,
  input  logic          scl_q,
  input  logic          sda_q,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] ptr
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  i2cs_state_t st, nxt;
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rx_byte;
  logic [6:0]    my_addr;

  assign rx_byte = {sh[DW-2:0], sda_q};
  assign my_addr = addr_sel ? ADDR_B : ADDR_A;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      nxt     <= S_IDLE;
      sh      <= '0;
      cnt     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      ptr     <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_SUB, S_WDAT: begin
            if (scl_rise) begin
              sh  <= rx_byte;
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) begin
                st <= S_ACKW;
                if (st == S_ADDR) begin
                  if (rx_byte[DW-1:1] == my_addr) nxt <= rx_byte[0] ? S_RD : S_SUB;
                  else st <= S_IGN;
                end else if (st == S_SUB) begin
                  ptr <= rx_byte[AW-1:0];
                  nxt <= S_WDAT;
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= rx_byte;
                  ptr     <= ptr + 1'b1;
                  nxt     <= S_WDAT;
                end
              end
            end
          end
          S_ACKW: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= S_ACKD;
          end
          S_ACKD: if (scl_fall) begin
            cnt <= '0;
            if (nxt == S_RD) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              st     <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              st     <= nxt;
            end
          end
          S_RD: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], 1'b0};
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) begin
                ptr <= ptr + 1'b1;
                st  <= S_RGAP;
              end
            end else if (scl_fall) begin
              sda_oe <= ~sh[DW-1];
            end
          end
          S_RGAP: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_RACK;
          end
          S_RACK: if (scl_rise) st <= sda_q ? S_IGN : S_RNXT;
          S_RNXT: if (scl_fall) begin
            sh     <= rd_data;
            sda_oe <= ~rd_data[DW-1];
            cnt    <= '0;
            st     <= S_RD;
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  // SDA driven by the target only moves while SCL is low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_q);
  // Ignored transfer stays silent
  p_ign_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> (!sda_oe && !wr_en));
  // Line released while host drives its acknowledge
  p_rack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK) |-> !sda_oe);
  // Write strobe is a single cycle
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // Pointer already stepped (modulo 256) when the write leaves
  p_wr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr == wr_addr + 1'b1));
endmodule

// File: rtl/regbus_i2c_slave.sv
module regbus_i2c_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_A      = 7'b1000100,
  parameter logic [6:0] ADDR_B      = 7'b1000110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data
);
  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_engine #(.DW(8), .AW(8), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)) u_eng (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr(rd_addr)
  );

  always_comb begin
    if (!rst_n) p_reset_quiet_r1: assert (!sda_oe && !wr_en);
  end
endmodule

// File: tb/regbus_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module regbus_i2c_slave_tb_top;
  localparam int Q = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, addr_sel, m_scl, m_sda;
  logic sda_oe, wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [7:0] bank [256];
  wire bus_sda = m_sda & ~sda_oe;

  regbus_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(m_scl), .sda_i(bus_sda),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign rd_data = bank[rd_addr];
  initial for (int i = 0; i < 256; i++) bank[i] = 8'(i) ^ 8'h5A;
  always @(posedge clk) if (wr_en) bank[wr_addr] <= wr_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0, quiet = 0;
  logic [15:0] exp_wr[$];
  logic [15:0] e;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Reference model compared on every clock: write stream and silence
  always @(negedge clk) if (rst_n && !done) begin
    if (wr_en) begin
      if (exp_wr.size() == 0) chk(0, "R3 unexpected write", {wr_addr, wr_data}, 0);
      else begin
        e = exp_wr.pop_front();
        chk({wr_addr, wr_data} == e, "R5 write", {wr_addr, wr_data}, e);
      end
    end
    if (quiet) chk(!sda_oe, "R3 target silent", sda_oe, 0);
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1; wq(); m_scl = 0;
    end
    wq(); m_sda = 1; wq(); m_scl = 1; wq();
    acked = (bus_sda == 1'b0);
    m_scl = 0; wq();
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] d);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(); m_scl = 1; wq(); d[i] = bus_sda; m_scl = 0;
    end
    wq(); m_sda = ack ? 1'b0 : 1'b1; wq(); m_scl = 1; wq(); m_scl = 0; wq(); m_sda = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    done = 1;
    report();
  end

  initial begin
    bit a;
    logic [7:0] d;
    rst_n = 0; addr_sel = 0; m_scl = 1; m_sda = 1;
    repeat (10) @(negedge clk);
    chk(!sda_oe, "R1 sda_oe in reset", sda_oe, 0);
    chk(!wr_en, "R1 wr_en in reset", wr_en, 0);
    chk(rd_addr == 8'h00, "R1 pointer in reset", rd_addr, 0);
    rst_n = 1; repeat (10) @(negedge clk);
    chk(!sda_oe && rd_addr == 0, "R1 after reset", rd_addr, 0);

    // Burst write from subaddress 0x10
    i2c_start();
    send_byte(8'h88, a); chk(a, "R2 address A ack", a, 1);
    send_byte(8'h10, a); chk(a, "R4 subaddress ack", a, 1);
    exp_wr.push_back(16'h10A1); exp_wr.push_back(16'h11B2); exp_wr.push_back(16'h12C3);
    send_byte(8'hA1, a); chk(a, "R4 data ack 0", a, 1);
    send_byte(8'hB2, a); chk(a, "R4 data ack 1", a, 1);
    send_byte(8'hC3, a); chk(a, "R4 data ack 2", a, 1);
    i2c_stop(); wq();
    chk(rd_addr == 8'h13, "R5 pointer after burst", rd_addr, 8'h13);
    chk(exp_wr.size() == 0, "R5 all writes seen", exp_wr.size(), 0);

    // One write, repeated START, read with no subaddress
    i2c_start();
    send_byte(8'h88, a);
    send_byte(8'h20, a);
    exp_wr.push_back(16'h2011);
    send_byte(8'h11, a);
    i2c_start();
    send_byte(8'h89, a); chk(a, "R9 read address after repeated START", a, 1);
    recv_byte(1, d); chk(d == (8'h21 ^ 8'h5A), "R6 read byte 0", d, 8'h21 ^ 8'h5A);
    recv_byte(0, d); chk(d == (8'h22 ^ 8'h5A), "R6 read byte 1", d, 8'h22 ^ 8'h5A);
    quiet = 1;
    wq(); m_scl = 1; wq();
    chk(bus_sda == 1'b1, "R7 SDA released after NACK", bus_sda, 1);
    m_scl = 0; wq();
    i2c_stop(); wq();
    chk(rd_addr == 8'h23, "R6 pointer after read", rd_addr, 8'h23);

    // Strap selects second address: first address is now a mismatch
    addr_sel = 1;
    i2c_start();
    send_byte(8'h88, a); chk(!a, "R3 mismatched address not acked", a, 0);
    send_byte(8'h40, a); chk(!a, "R3 byte after mismatch", a, 0);
    send_byte(8'h55, a); chk(!a, "R3 second byte after mismatch", a, 0);
    i2c_stop(); quiet = 0;

    // Wrap across 0xFF
    i2c_start();
    send_byte(8'h8C, a); chk(a, "R2 address B ack", a, 1);
    send_byte(8'hFE, a); chk(a, "R4 subaddress ack wrap", a, 1);
    exp_wr.push_back(16'hFE01); exp_wr.push_back(16'hFF02); exp_wr.push_back(16'h0003);
    send_byte(8'h01, a);
    send_byte(8'h02, a);
    send_byte(8'h03, a); chk(a, "R4 data ack after wrap", a, 1);
    i2c_stop(); wq();
    chk(rd_addr == 8'h01, "R8 pointer wrapped", rd_addr, 8'h01);
    chk(exp_wr.size() == 0, "R8 wrapped writes seen", exp_wr.size(), 0);

    i2c_start();
    send_byte(8'h8D, a); chk(a, "R2 read address B ack", a, 1);
    recv_byte(0, d); chk(d == (8'h01 ^ 8'h5A), "R6 read after wrap", d, 8'h01 ^ 8'h5A);
    i2c_stop(); wq();
    chk(rd_addr == 8'h02, "R6 pointer after wrapped read", rd_addr, 8'h02);

    // After STOP, bytes without START are ignored
    quiet = 1;
    m_scl = 0; wq();
    send_byte(8'h8C, a); chk(!a, "R10 no ack without START", a, 0);
    m_scl = 1; wq(); quiet = 0;
    i2c_start();
    send_byte(8'h8C, a); chk(a, "R10 ack after new START", a, 1);
    i2c_stop(); wq();
    chk(exp_wr.size() == 0, "R3 no pending writes", exp_wr.size(), 0);

    done = 1;
    report();
  end
endmodule